// File: doc/BRIEF.md
# Storage Port Activity LED Controller

This block drives four active-low activity LEDs from single-cycle activity strobes raised by four storage ports. Each strobe starts a per-channel stretch window of `HOLD_CYCLES` clock cycles, so a brief burst of port activity stays visible to the eye. Another strobe on the same channel during an open window restarts the window at full length.

The way channels map onto LEDs depends on an active-low mode strap, which is captured while reset is asserted. With the strap low (direct mode), each channel drives the LED with the same index. With the strap high (compatibility mode), the channels are ORed in pairs: channels 0 and 1 drive LED0, channels 2 and 3 drive LED1, and LED2 and LED3 stay dark. The LED outputs are registered, which gives the pin-sharing logic downstream a clean, glitch-free set of levels.

Top module: `activity_led_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, all four `led_n_o` bits are 1 (off).
- R2: In compatibility mode, `led_n_o[0]` is 0 exactly while channel 0 or channel 1 is active, and `led_n_o[1]` is 0 exactly while channel 2 or channel 3 is active.
- R3: In direct mode, `led_n_o[i]` is 0 exactly while channel i is active, for i = 0 to 3.
- R4: In compatibility mode, `led_n_o[2]` and `led_n_o[3]` stay 1 whatever the strobes do.
- R5: A single-cycle strobe on `act_strobe_i[i]` (bit i is channel i) keeps channel i active for exactly `HOLD_CYCLES` consecutive cycles.
- R6: A strobe that arrives while a channel's window is open restarts that window, which then lasts a full `HOLD_CYCLES` from the latest strobe.
- R7: The mode is set by the value of `direct_mode_n_i` in the last reset cycle (0 = direct, 1 = compatibility). Changes on that pin after reset is released have no effect until the next reset.
- R8: The LED output goes low at the clock edge after the edge that samples the strobe, and it returns high `HOLD_CYCLES` edges after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_strobe_i | input | 4 | Per-channel activity strobe; bit i is channel i |
| direct_mode_n_i | input | 1 | Mode strap, low selects direct mode; captured during reset |
| led_n_o | output | 4 | Active-low LED drive; bit i is LED i |

## Verification
A strobe sampled at clock edge k loads that channel's counter at edge k. The LED register picks up the active state one edge later, so the LED is low after edges k+1 through k+`HOLD_CYCLES` and high again after edge k+`HOLD_CYCLES`+1. The bench records, at every rising edge, the edge number of each channel's most recent strobe. From that record it derives the expected LED vector for the following falling edge, where it compares all four outputs. Directed checks count low cycles at falling edges, starting from the first falling edge after the strobe edge. They confirm both the one-cycle latency and the window length.

// File: rtl/led_act_pkg.sv
package led_act_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_DIRECT = 1'b1
    } led_mode_e;

    // Active-high lamp vector from per-channel activity for a given mode.
    function automatic logic [NUM_CH-1:0] route_leds(led_mode_e m,
                                                     logic [NUM_CH-1:0] act);
        logic [NUM_CH-1:0] on;
        for (int i = 0; i < NUM_CH; i++) begin
            if (m == MODE_DIRECT) begin
                on[i] = act[i];
            end else if (i < NUM_CH / 2) begin
                on[i] = act[(2 * i) % NUM_CH] | act[(2 * i + 1) % NUM_CH];
            end else begin
                on[i] = 1'b0;
            end
        end
        return on;
    endfunction

endpackage

// File: rtl/act_stretch.sv
module act_stretch #(
    parameter int HOLD_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic active_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (strobe_i) begin
            cnt_q <= CW'(HOLD_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign active_o = (cnt_q != '0);

    // R6: every strobe reloads the full window
    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (cnt_q == CW'(HOLD_CYCLES)));

    // R5: an open window counts down by one per cycle
    p_decay_r5: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R5: an idle channel stays idle without a strobe
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/mode_strap_latch.sv
module mode_strap_latch
    import led_act_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strap_n_i,
    output led_mode_e mode_o
);
    led_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= strap_n_i ? MODE_COMPAT : MODE_DIRECT;
        end
    end

    assign mode_o = mode_q;

    // R7: the captured mode never moves once reset has been released
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

endmodule

// File: rtl/led_route.sv
module led_route
    import led_act_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  led_mode_e         mode_i,
    input  logic [NUM_CH-1:0] act_i,
    output logic [NUM_CH-1:0] led_n_o
);
    logic [NUM_CH-1:0] led_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_n_q <= '1;
        end else begin
            led_n_q <= ~route_leds(mode_i, act_i);
        end
    end

    assign led_n_o = led_n_q;

    // R4: the upper pair stays dark in compatibility mode
    p_upper_dark_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_COMPAT) |-> (led_n_q[3:2] == 2'b11));

    // R2: paired fold, one cycle after the activity
    p_pair_fold_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_COMPAT) |=>
        (led_n_q[1:0] == ~{$past(act_i[3] | act_i[2]), $past(act_i[1] | act_i[0])}));

    // R3: one channel per lamp, one cycle after the activity
    p_direct_map_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_DIRECT) |=> (led_n_q == ~$past(act_i)));

endmodule

// File: rtl/activity_led_ctrl.sv
module activity_led_ctrl
    import led_act_pkg::*;
#(
    parameter int HOLD_CYCLES = 1_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] act_strobe_i,
    input  logic       direct_mode_n_i,
    output logic [3:0] led_n_o
);
    logic [NUM_CH-1:0] chan_active;
    led_mode_e         mode;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            act_stretch #(
                .HOLD_CYCLES(HOLD_CYCLES)
            ) u_stretch (
                .clk     (clk),
                .rst     (rst),
                .strobe_i(act_strobe_i[g]),
                .active_o(chan_active[g])
            );
        end
    endgenerate

    mode_strap_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .strap_n_i(direct_mode_n_i),
        .mode_o   (mode)
    );

    led_route u_route (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .act_i  (chan_active),
        .led_n_o(led_n_o)
    );

    // R1: a reset cycle leaves every lamp off
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (led_n_o == 4'b1111));

endmodule

// File: tb/tb_activity_led_ctrl.sv
module tb_activity_led_ctrl;
    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] strb = '0;
    logic       strap = 1'b1;
    logic [3:0] led_n;

    int n_chk = 0;
    int n_err = 0;
    int edge_n = 0;
    int last_k [4] = '{-1000, -1000, -1000, -1000};
    bit exp_direct = 1'b0;
    bit in_rst = 1'b1;
    bit [3:0] exp_on = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    activity_led_ctrl #(.HOLD_CYCLES(HOLD)) dut (
        .clk            (clk),
        .rst            (rst),
        .act_strobe_i   (strb),
        .direct_mode_n_i(strap),
        .led_n_o        (led_n)
    );

    // Reference: which channels are lit after this edge.
    always @(posedge clk) begin
        edge_n = edge_n + 1;
        in_rst = rst;
        if (rst) exp_direct = !strap;
        for (int ch = 0; ch < 4; ch++) begin
            if (rst) begin
                exp_on[ch] = 1'b0;
                last_k[ch] = -1000;
            end else begin
                exp_on[ch] = (edge_n - last_k[ch] >= 1) && (edge_n - last_k[ch] <= HOLD);
                if (strb[ch]) last_k[ch] = edge_n;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at edge %0d", tag, act, expv, edge_n);
        end
    endtask

    // Continuous comparison at every falling edge.
    always @(negedge clk) begin
        if (edge_n > 0 && !done) begin
            bit [3:0] e;
            string tag;
            if (in_rst) e = 4'hF;
            else if (exp_direct) e = ~exp_on;
            else e = {2'b11, ~(exp_on[3] | exp_on[2]), ~(exp_on[1] | exp_on[0])};
            for (int i = 0; i < 4; i++) begin
                if (in_rst) tag = "R1";
                else if (strap == exp_direct) tag = "R7";
                else if (exp_direct) tag = "R3";
                else if (i < 2) tag = "R2";
                else tag = "R4";
                check(led_n[i] == e[i], tag, led_n[i], e[i]);
            end
        end
    end

    task automatic do_reset(input bit s);
        @(negedge clk);
        rst = 1'b1;
        strap = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(led_n == 4'hF, "R1", led_n, 4'hF);
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        strb = m;
        @(negedge clk);
        strb = '0;
    endtask

    initial begin
        // Sweep every strobe pattern in both modes, plus overlapping pairs.
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            for (int m = 0; m < 16; m++) begin
                pulse(m[3:0]);
                repeat (HOLD + 2) @(negedge clk);
            end
            for (int a = 1; a < 16; a += 3) begin
                pulse(a[3:0]);
                @(negedge clk);
                pulse(4'(15 - a));
                repeat (HOLD + 2) @(negedge clk);
            end
        end

        // R5 / R8: window length and latency in direct mode.
        begin
            int lows = 0;
            int first = -1;
            int last = -1;
            do_reset(1'b0);
            pulse(4'b0001);
            for (int i = 1; i <= HOLD + 3; i++) begin
                @(negedge clk);
                if (!led_n[0]) begin
                    lows++;
                    if (first < 0) first = i;
                    last = i;
                end
            end
            check(lows == HOLD, "R5", lows, HOLD);
            check(first == 1, "R8", first, 1);
            check(last == HOLD, "R8", last, HOLD);
        end

        // R6: a second strobe inside the window restarts it.
        begin
            int lows = 0;
            pulse(4'b0010);
            @(negedge clk);
            pulse(4'b0010);
            check(led_n[1] == 1'b0, "R6", led_n[1], 0);
            for (int i = 1; i <= HOLD + 3; i++) begin
                @(negedge clk);
                if (!led_n[1]) lows++;
            end
            check(lows == HOLD, "R6", lows, HOLD);
        end

        // R7: a strap change after reset release does not switch the mode.
        do_reset(1'b1);
        strap = 1'b0;
        repeat (2) @(negedge clk);
        pulse(4'b1000);
        @(negedge clk);
        check(led_n == 4'b1101, "R7", led_n, 4'b1101);
        repeat (HOLD + 2) @(negedge clk);
        check(led_n == 4'b1111, "R7", led_n, 4'b1111);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule